// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block is a hardware master that loads a configuration image into a target FPGA through the target's slave-mode SPI port. On a start request it pulls the target's active-low reset and chip-select low together, holds reset for one microsecond, releases it and confirms the target's configuration-done input is low. It then waits 1200 microseconds with chip-select still low so the target can finish its internal preparation. After that it raises chip-select for one SCLK period, drops it again, and streams image bytes from a valid/ready byte source out on SCLK and MOSI.

When the source marks its last byte and that byte has been shifted, the block reads configuration-done again. If it is high, the block sends seven zero bytes (56 SCLK cycles, at least the 49 the target needs to start the loaded design) and pulses `done_o`. If it is low, or if configuration-done was already high straight after reset, the block releases chip-select and pulses `err_o` with a code. A request flagged as partial reconfiguration is refused at once and no pin is touched. All times are counted in system clocks from the `CLK_HZ` parameter. The SCLK rate, `CLK_HZ / (2 * SCK_DIV)`, is checked against the 1 MHz to 25 MHz window when the design is elaborated.

The controller states are IDLE, RST_HOLD, RST_CHECK, HOUSEKEEP, CS_GAP, LOAD, SHIFT, CHECK_DONE, ACT_LOAD, ACT_SHIFT, COMPLETE, ERR_RST, ERR_NDONE and ERR_UNSUP. The transitions are:
- IDLE goes to RST_HOLD on start, or to ERR_UNSUP on start with the partial flag set.
- RST_HOLD goes to RST_CHECK when the hold time expires.
- RST_CHECK goes to ERR_RST if configuration-done is high, otherwise to HOUSEKEEP.
- HOUSEKEEP goes to CS_GAP when its wait expires, and CS_GAP goes to LOAD when the gap expires.
- LOAD goes to SHIFT on a valid byte.
- SHIFT goes back to LOAD, or to CHECK_DONE after the last byte.
- CHECK_DONE goes to ACT_LOAD if configuration-done is high, otherwise to ERR_NDONE.
- ACT_LOAD and ACT_SHIFT alternate until seven zero bytes have been sent, then go to COMPLETE.
- COMPLETE and every ERR state go back to IDLE.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After system reset the outputs are: `cfg_cs_n_o`=1, `cfg_rst_n_o`=1, `cfg_sck_o`=0, `cfg_mosi_o`=0, `in_ready_o`=0, `busy_o`=0, `done_o`=0, `err_o`=0 and `err_code_o`=0.
- R2: An accepted start drives `cfg_rst_n_o` and `cfg_cs_n_o` low in the same cycle, on the first clock edge after start. `cfg_rst_n_o` stays low for exactly 1 µs of system clocks (`CLK_HZ`/1e6 cycles), and it is never low while `cfg_cs_n_o` is high.
- R3: One cycle after reset is released, `cfg_done_i` is sampled. If it is high, the block raises `err_o` with code 1 (reset failure), drives `cfg_cs_n_o` high and sends no SCLK edge.
- R4: After a clean reset check, `cfg_cs_n_o` stays low for at least 1200 µs of system clocks, and for at most two cycles more. Then it goes high for at least one SCLK period (2·`SCK_DIV` cycles) before the first data bit.
- R5: Bytes are sent MSB first in SPI mode 0. SCLK idles low, each half period lasts `SCK_DIV` clocks, and MOSI changes only while SCLK is low, so it is stable on every rising edge.
- R6: `in_ready_o` is high only in the data phase while no byte is shifting. It is low on the cycle after each accepted byte and throughout the reset, housekeeping and gap phases.
- R7: After the byte marked last has been shifted, if `cfg_done_i` is low the block raises `err_o` with code 2 (not done). It sends no further SCLK edges and drives `cfg_cs_n_o` high.
- R8: After the byte marked last has been shifted, if `cfg_done_i` is high the block sends 7 zero bytes (56 SCLK rising edges with MOSI=0) and then pulses `done_o`, with `err_code_o`=0.
- R9: A start with `partial_i`=1 raises `err_o` with code 3 (unsupported) on the next cycle. `cfg_cs_n_o` and `cfg_rst_n_o` stay high and SCLK does not toggle.
- R10: `busy_o` is high from the cycle after an accepted start through the cycle of the `done_o` or `err_o` pulse, and low after it. A start while busy is ignored and causes no second reset.
- R11: `done_o` and `err_o` are single-cycle pulses and are never high together. `err_code_o` keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the block |
| start_i | input | 1 | Request a configuration load (one-cycle pulse) |
| partial_i | input | 1 | Flags the request as partial reconfiguration (refused) |
| in_data_i | input | 8 | Image byte from the source |
| in_valid_i | input | 1 | Source byte valid |
| in_last_i | input | 1 | Marks the final image byte |
| in_ready_o | output | 1 | Block accepts a byte this cycle |
| cfg_rst_n_o | output | 1 | Target reset, active low |
| cfg_cs_n_o | output | 1 | Target SPI chip-select, active low |
| cfg_sck_o | output | 1 | SPI clock to the target |
| cfg_mosi_o | output | 1 | SPI data to the target |
| cfg_done_i | input | 1 | Target configuration-done indication |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | One-cycle pulse: load finished successfully |
| err_o | output | 1 | One-cycle pulse: load aborted |
| err_code_o | output | 2 | 0 none, 1 reset failure, 2 not done, 3 unsupported |

## Verification
The assertions check the pin relations that must hold on every cycle: reset is asserted only under chip-select, SCLK toggles only with chip-select low and reset high, and MOSI is stable while SCLK is high. They also check that ready implies an active data phase, that done and error pulses are exclusive and end busy, that the code matches the kind of pulse, and that a refused request leaves the pins idle. The bench scenarios show what needs a whole run to observe. These are the exact reset hold and housekeeping lengths, the chip-select gap, the bit order of the captured bytes, the count of 56 activation edges, the choice between error codes 1 and 2 depending on configuration-done, and that a start issued mid-load does not restart the sequence.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_HOLD,
        ST_RST_CHECK,
        ST_HOUSEKEEP,
        ST_CS_GAP,
        ST_LOAD,
        ST_SHIFT,
        ST_CHECK_DONE,
        ST_ACT_LOAD,
        ST_ACT_SHIFT,
        ST_COMPLETE,
        ST_ERR_RST,
        ST_ERR_NDONE,
        ST_ERR_UNSUP
    } ldr_state_e;

    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_RESET       = 2'd1,
        ERR_NOT_DONE    = 2'd2,
        ERR_UNSUPPORTED = 2'd3
    } ldr_err_e;

endpackage

// File: rtl/cfg_interval_timer.sv
module cfg_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx #(
    parameter int SCK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] byte_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int DW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(SCK_DIV - 1);

    logic [7:0]    sr_q;
    logic [2:0]    bit_q;
    logic [DW-1:0] div_q;
    logic          sck_q;
    logic          busy_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            bit_q  <= '0;
            div_q  <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (go_i) begin
                    sr_q   <= byte_i;
                    bit_q  <= '0;
                    div_q  <= '0;
                    sck_q  <= 1'b0;
                    busy_q <= 1'b1;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                sck_q <= ~sck_q;
                if (sck_q) begin
                    // falling edge: present the next bit
                    sr_q  <= {sr_q[6:0], 1'b0};
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sck_o  = sck_q;
    assign mosi_o = sr_q[7];
    assign busy_o = busy_q;
    assign done_o = done_q;
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int SCK_DIV     = 2,
    parameter int RST_US      = 1,
    parameter int HK_US       = 1200,
    parameter int ACT_CLKS    = 49
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic [7:0] in_data_i,
    input  logic       in_valid_i,
    input  logic       in_last_i,
    output logic       in_ready_o,
    output logic       cfg_rst_n_o,
    output logic       cfg_cs_n_o,
    output logic       cfg_sck_o,
    output logic       cfg_mosi_o,
    input  logic       cfg_done_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [1:0] err_code_o
);
    localparam int CYC_PER_US = (CLK_HZ + 999_999) / 1_000_000;
    localparam int RST_CYC    = CYC_PER_US * RST_US;
    localparam int HK_CYC     = CYC_PER_US * HK_US;
    localparam int GAP_CYC    = 2 * SCK_DIV;
    localparam int TW         = $clog2(HK_CYC + 1);
    localparam int ACT_BYTES  = (ACT_CLKS + 7) / 8;
    localparam int AW         = $clog2(ACT_BYTES + 1);
    localparam int SCK_HZ     = CLK_HZ / (2 * SCK_DIV);

    generate
        if (SCK_HZ < 1_000_000 || SCK_HZ > 25_000_000) begin : g_bad_sck
            $error("SCLK rate outside 1..25 MHz for this CLK_HZ and SCK_DIV");
        end
    endgenerate

    ldr_state_e    state_q, nxt;
    ldr_err_e      code_q;
    logic          last_q;
    logic [AW-1:0] act_q;

    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          tx_go, tx_busy, tx_done;
    logic [7:0]    tx_byte;

    cfg_interval_timer #(.W(TW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    spi_byte_tx #(.SCK_DIV(SCK_DIV)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (tx_go),
        .byte_i (tx_byte),
        .sck_o  (cfg_sck_o),
        .mosi_o (cfg_mosi_o),
        .busy_o (tx_busy),
        .done_o (tx_done)
    );

    // next-state logic
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) nxt = partial_i ? ST_ERR_UNSUP : ST_RST_HOLD;
            ST_RST_HOLD:   if (tmr_exp) nxt = ST_RST_CHECK;
            ST_RST_CHECK:  nxt = cfg_done_i ? ST_ERR_RST : ST_HOUSEKEEP;
            ST_HOUSEKEEP:  if (tmr_exp) nxt = ST_CS_GAP;
            ST_CS_GAP:     if (tmr_exp) nxt = ST_LOAD;
            ST_LOAD:       if (in_valid_i) nxt = ST_SHIFT;
            ST_SHIFT:      if (tx_done) nxt = last_q ? ST_CHECK_DONE : ST_LOAD;
            ST_CHECK_DONE: nxt = cfg_done_i ? ST_ACT_LOAD : ST_ERR_NDONE;
            ST_ACT_LOAD:   nxt = ST_ACT_SHIFT;
            ST_ACT_SHIFT:  if (tx_done) nxt = (act_q == AW'(1)) ? ST_COMPLETE : ST_ACT_LOAD;
            ST_COMPLETE, ST_ERR_RST, ST_ERR_NDONE, ST_ERR_UNSUP: nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= ERR_NONE;
            last_q  <= 1'b0;
            act_q   <= '0;
        end else begin
            state_q <= nxt;
            if (state_q == ST_IDLE && start_i)
                code_q <= partial_i ? ERR_UNSUPPORTED : ERR_NONE;
            if (state_q == ST_RST_CHECK && cfg_done_i)
                code_q <= ERR_RESET;
            if (state_q == ST_CHECK_DONE && !cfg_done_i)
                code_q <= ERR_NOT_DONE;
            if (state_q == ST_LOAD && in_valid_i)
                last_q <= in_last_i;
            if (state_q == ST_CHECK_DONE)
                act_q <= AW'(ACT_BYTES);
            else if (state_q == ST_ACT_SHIFT && tx_done)
                act_q <= act_q - 1'b1;
        end
    end

    // outputs and datapath controls
    always_comb begin
        cfg_cs_n_o  = 1'b1;
        cfg_rst_n_o = 1'b1;
        in_ready_o  = 1'b0;
        done_o      = 1'b0;
        err_o       = 1'b0;
        tx_go       = 1'b0;
        tx_byte     = 8'h00;
        unique case (state_q)
            ST_RST_HOLD: begin
                cfg_cs_n_o  = 1'b0;
                cfg_rst_n_o = 1'b0;
            end
            ST_RST_CHECK, ST_HOUSEKEEP, ST_SHIFT, ST_CHECK_DONE, ST_ACT_SHIFT:
                cfg_cs_n_o = 1'b0;
            ST_LOAD: begin
                cfg_cs_n_o = 1'b0;
                in_ready_o = ~tx_busy;
                tx_go      = in_valid_i;
                tx_byte    = in_data_i;
            end
            ST_ACT_LOAD: begin
                cfg_cs_n_o = 1'b0;
                tx_go      = 1'b1;
            end
            ST_COMPLETE: done_o = 1'b1;
            ST_ERR_RST, ST_ERR_NDONE, ST_ERR_UNSUP: err_o = 1'b1;
            default: ;
        endcase

        tmr_load = (nxt != state_q) &&
                   (nxt == ST_RST_HOLD || nxt == ST_HOUSEKEEP || nxt == ST_CS_GAP);
        if (nxt == ST_RST_HOLD)       tmr_val = TW'(RST_CYC - 1);
        else if (nxt == ST_HOUSEKEEP) tmr_val = TW'(HK_CYC - 1);
        else                          tmr_val = TW'(GAP_CYC - 1);
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign err_code_o = code_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready_o,
    input logic       cfg_rst_n_o,
    input logic       cfg_cs_n_o,
    input logic       cfg_sck_o,
    input logic       cfg_mosi_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic [1:0] err_code_o
);
    // R2
    rst_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_n_o |-> !cfg_cs_n_o);

    // R5
    sck_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sck_o |-> (!cfg_cs_n_o && cfg_rst_n_o && busy_o));

    // R5
    mosi_hold_high_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sck_o |-> $stable(cfg_mosi_o));

    // R6
    ready_in_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (busy_o && !cfg_cs_n_o && cfg_rst_n_o && !cfg_sck_o));

    // R11
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R10
    pulse_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> busy_o ##1 !busy_o);

    // R11
    code_matches_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o |-> err_code_o != 2'd0) and (done_o |-> err_code_o == 2'd0));

    // R9
    unsup_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && err_code_o == 2'd3) |-> (cfg_cs_n_o && cfg_rst_n_o && !cfg_sck_o));

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cfg_cs_n_o && cfg_rst_n_o && !cfg_sck_o && !in_ready_o));
endmodule

bind fpga_cfg_loader cfg_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready_o  (in_ready_o),
    .cfg_rst_n_o (cfg_rst_n_o),
    .cfg_cs_n_o  (cfg_cs_n_o),
    .cfg_sck_o   (cfg_sck_o),
    .cfg_mosi_o  (cfg_mosi_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o)
);

// File: tb/sim_fpga_cfg_loader.sv
`timescale 1ns/1ps
module sim_fpga_cfg_loader;
    localparam int CLK_HZ  = 4_000_000;
    localparam int SCK_DIV = 2;
    localparam int RST_CYC = 4;
    localparam int HK_CYC  = 4800;
    localparam int GAP_CYC = 2 * SCK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, partial_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_valid_i = 1'b0, in_last_i = 1'b0;
    logic       in_ready_o, cfg_rst_n_o, cfg_cs_n_o, cfg_sck_o, cfg_mosi_o;
    logic       cfg_done_i = 1'b0;
    logic       busy_o, done_o, err_o;
    logic [1:0] err_code_o;

    int checks = 0, fails = 0;
    int n_sck, n_rst_low, n_rst_nocs, n_done, n_err, n_rdy, n_rdy_bad, n_rst_fall;
    logic [1:0]   err_seen;
    logic [127:0] cap;
    logic         rst_prev = 1'b1;

    always #5 clk = ~clk;

    fpga_cfg_loader #(.CLK_HZ(CLK_HZ), .SCK_DIV(SCK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .partial_i(partial_i),
        .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
        .in_ready_o(in_ready_o), .cfg_rst_n_o(cfg_rst_n_o), .cfg_cs_n_o(cfg_cs_n_o),
        .cfg_sck_o(cfg_sck_o), .cfg_mosi_o(cfg_mosi_o), .cfg_done_i(cfg_done_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    // target-side SPI capture: sample MOSI on SCLK rising edges under chip-select
    always @(posedge cfg_sck_o) begin
        if (!cfg_cs_n_o) begin
            cap   = {cap[126:0], cfg_mosi_o};
            n_sck = n_sck + 1;
        end
    end

    always @(negedge clk) begin
        if (!cfg_rst_n_o) n_rst_low = n_rst_low + 1;
        if (!cfg_rst_n_o && cfg_cs_n_o) n_rst_nocs = n_rst_nocs + 1;
        if (done_o) n_done = n_done + 1;
        if (err_o) begin n_err = n_err + 1; err_seen = err_code_o; end
        if (in_ready_o) n_rdy = n_rdy + 1;
        if (in_ready_o && cfg_cs_n_o) n_rdy_bad = n_rdy_bad + 1;
        if (rst_prev && !cfg_rst_n_o) n_rst_fall = n_rst_fall + 1;
        rst_prev = cfg_rst_n_o;
    end

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input longint act, input longint lo, input longint hi, input string what);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); #1;
        n_sck = 0; n_rst_low = 0; n_rst_nocs = 0; n_done = 0; n_err = 0;
        n_rdy = 0; n_rdy_bad = 0; n_rst_fall = 0; err_seen = 2'd0; cap = '0;
    endtask

    task automatic pulse_start(input logic partial);
        @(negedge clk); start_i = 1'b1; partial_i = partial;
        @(negedge clk); start_i = 1'b0; partial_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic last);
        in_data_i = d; in_last_i = last; in_valid_i = 1'b1;
        while (!in_ready_o) @(negedge clk);
        @(negedge clk);
        in_valid_i = 1'b0; in_last_i = 1'b0;
        // R6: ready must drop while the accepted byte shifts
        chk("R6", in_ready_o, 0, "ready during shift");
    endtask

    task automatic t_reset();
        chk("R1", {cfg_cs_n_o, cfg_rst_n_o, cfg_sck_o, cfg_mosi_o}, 4'b1100, "pins after reset");
        chk("R1", {in_ready_o, busy_o, done_o, err_o}, 0, "flags after reset");
        chk("R1", err_code_o, 0, "code after reset");
    endtask

    task automatic t_unsupported();
        clear_mon();
        @(negedge clk); start_i = 1'b1; partial_i = 1'b1;
        @(negedge clk); start_i = 1'b0; partial_i = 1'b0;
        chk("R9", err_o, 1, "unsupported err pulse");
        chk("R9", err_code_o, 3, "unsupported code");
        chk("R9", {cfg_cs_n_o, cfg_rst_n_o}, 2'b11, "pins untouched");
        @(negedge clk);
        chk("R10", busy_o, 0, "busy after unsupported");
        chk("R9", n_rst_fall + n_sck, 0, "no reset or clock activity");
    endtask

    task automatic t_reset_fail();
        clear_mon();
        cfg_done_i = 1'b1;
        pulse_start(1'b0);
        chk("R2", {cfg_cs_n_o, cfg_rst_n_o}, 2'b00, "cs and reset low together");
        wait_idle();
        cfg_done_i = 1'b0;
        chk("R2", n_rst_low, RST_CYC, "reset hold cycles");
        chk("R2", n_rst_nocs, 0, "reset low without cs");
        chk("R3", n_err, 1, "reset failure err pulses");
        chk("R3", err_seen, 1, "reset failure code");
        chk("R3", n_sck + n_rdy, 0, "no data phase after reset failure");
        chk("R3", cfg_cs_n_o, 1, "cs released");
        chk("R11", err_code_o, 1, "code held in idle");
    endtask

    task automatic t_good_load();
        int hk, gap, rdy_hk;
        clear_mon();
        cfg_done_i = 1'b0;
        pulse_start(1'b0);
        while (!cfg_rst_n_o) @(negedge clk);
        hk = 0; rdy_hk = 0;
        while (!cfg_cs_n_o) begin
            hk++;
            if (in_ready_o) rdy_hk++;
            start_i = (hk == 100);   // R10: start while busy must be ignored
            @(negedge clk);
        end
        start_i = 1'b0;
        chk_range("R4", hk, HK_CYC, HK_CYC + 2, "cs low housekeeping cycles");
        chk("R6", rdy_hk, 0, "ready during housekeeping");
        gap = 0;
        while (cfg_cs_n_o) begin gap++; @(negedge clk); end
        chk_range("R4", gap, GAP_CYC, GAP_CYC + 2, "cs high gap cycles");
        chk("R4", n_sck, 0, "no SCLK before gap ends");
        send_byte(8'hA5, 1'b0);
        send_byte(8'h3C, 1'b0);
        cfg_done_i = 1'b1;
        send_byte(8'h81, 1'b1);
        wait_idle();
        cfg_done_i = 1'b0;
        chk("R5", cap[79:72], 8'hA5, "first byte MSB first");
        chk("R5", cap[71:64], 8'h3C, "second byte");
        chk("R5", cap[63:56], 8'h81, "last byte");
        chk("R8", n_sck, 80, "total SCLK rising edges");
        chk("R8", cap[55:0], 0, "activation bits zero");
        chk("R8", n_done, 1, "done pulses");
        chk("R8", n_err, 0, "no error on good load");
        chk("R8", err_code_o, 0, "code after success");
        chk("R10", n_rst_fall, 1, "single reset despite second start");
        chk("R6", n_rdy_bad, 0, "ready while cs high");
        chk("R2", n_rst_low, RST_CYC, "reset hold on good load");
    endtask

    task automatic t_not_done();
        clear_mon();
        cfg_done_i = 1'b0;
        pulse_start(1'b0);
        while (!in_ready_o) @(negedge clk);
        send_byte(8'h5A, 1'b1);
        wait_idle();
        chk("R7", n_err, 1, "not-done err pulses");
        chk("R7", err_seen, 2, "not-done code");
        chk("R7", n_sck, 8, "no activation clocks");
        chk("R5", cap[7:0], 8'h5A, "single byte captured");
        chk("R7", n_done + (cfg_cs_n_o ? 0 : 1), 0, "no done, cs released");
        repeat (5) @(negedge clk);
        chk("R11", err_code_o, 2, "code held until next start");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsupported();
        t_reset_fail();
        t_good_load();
        t_not_done();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule